// File: doc/BRIEF.md
# SD Host Interrupt Status Controller

This block keeps the event status and interrupt mask of an SD/MMC host controller and produces its single interrupt line. The command/data engine and the bus sequencer report events as one-cycle pulses. Each pulse sets a sticky status flag. Software reads the status word and clears flags by writing ones to them. The interrupt output is high while at least one flag is set whose mask bit is also set.

Both registers sit on a simple 32-bit register port. The port has a write strobe, a byte address and write data, and its read data follows the address combinationally. The upper half of the status word is not stored. It shows live inputs: engine busy, descriptor walker busy, and a 14-bit field of bus-state and line levels. Three class outputs summarise the flags for nearby logic: any timeout, any error, and chain complete.

Top module: `sdhost_irq_status`

## Requirements
- R1: After reset the stored event flags are 0 and the mask register is 0. `irq`, `timeout_any`, `error_any`, `chain_done` and `secure_cfg` are all 0.
- R2: An event pulse sampled at a clock edge sets its flag at that edge. The flags are read at address STAT_OFS (default 0x48) in these bit positions:
  - bits 7:0: per-line receive-data error
  - bit 8: transmit-data error
  - bit 9: descriptor error
  - bit 10: response error
  - bit 11: response timeout
  - bit 12: descriptor timeout
  - bit 13: chain end
  - bit 14: response status
  - bit 15: SDIO card interrupt
- R3: A write to STAT_OFS clears each flag whose bit 15:0 in the write data is 1. Flags whose write-data bit is 0 keep their value.
- R4: If an event and a write-one-clear hit the same flag at the same edge, the flag is left set.
- R5: The mask register at IEN_OFS (default 0x4C) stores write-data bits 16:0. It reads back with bits 31:17 as 0. Bit 16 drives `secure_cfg`.
- R6: `irq` is registered. It is 1 in the cycle after one where some flag bit and its mask bit 15:0 are both 1, and 0 in the cycle after one where no such pair exists.
- R7: A flag whose mask bit is 0 is still recorded and readable, but it does not raise `irq`.
- R8: Status bits 31:16 read the live inputs: bit 31 is `core_busy`, bit 30 is `desc_busy`, and bits 29:16 are `bus_live`. Writes do not affect them.
- R9: The class outputs are taken from the stored flags:
  - `timeout_any` is flag 11 OR flag 12.
  - `error_any` is the OR of flags 10, 9, 8 and 7:0.
  - `chain_done` is flag 13.
- R10: Writing only bit 15 to STAT_OFS acknowledges the SDIO interrupt and leaves all other flags unchanged.
- R11: Any other address reads as 0, and a write to it changes neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | AW | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr |
| ev_rx_err | input | 8 | Per-line receive error pulses |
| ev_tx_err | input | 1 | Transmit data error pulse |
| ev_desc_err | input | 1 | Descriptor error pulse |
| ev_resp_err | input | 1 | Response error pulse |
| ev_resp_to | input | 1 | Response timeout pulse |
| ev_desc_to | input | 1 | Descriptor timeout pulse |
| ev_chain_end | input | 1 | End of descriptor chain pulse |
| ev_resp_stat | input | 1 | Response status pulse |
| ev_sdio | input | 1 | SDIO card interrupt pulse |
| core_busy | input | 1 | Live engine busy level |
| desc_busy | input | 1 | Live descriptor busy level |
| bus_live | input | 14 | Live bus state and line levels |
| irq | output | 1 | Registered masked interrupt |
| secure_cfg | output | 1 | Mask register bit 16 |
| timeout_any | output | 1 | Any timeout flag set |
| error_any | output | 1 | Any error flag set |
| chain_done | output | 1 | Chain end flag set |

## Verification
The bench drives an event and a clear of the same flag at the same edge. A design that gives the clear priority would lose a completion that arrives during acknowledgement, and the flag would read 0.

It writes only the SDIO bit to the status register and writes ones to the live upper half. A design that decodes the write mask wrongly would wipe the chain-end flag or latch the busy inputs.

It checks `irq` one cycle after each flag and mask change. A combinational or two-stage interrupt path would show up as a one-cycle error. It also confirms that masked flags are still recorded, and that unmapped writes leave both registers unchanged.

// File: rtl/sdhost_irq_status.sv
module sdhost_irq_status #(
  parameter int AW       = 8,
  parameter int NFLAG    = 16,
  parameter int NIEN     = 17,
  parameter int NLIVE    = 14,
  parameter logic [AW-1:0] STAT_OFS = 8'h48,
  parameter logic [AW-1:0] IEN_OFS  = 8'h4C
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic [7:0]    ev_rx_err,
  input  logic          ev_tx_err,
  input  logic          ev_desc_err,
  input  logic          ev_resp_err,
  input  logic          ev_resp_to,
  input  logic          ev_desc_to,
  input  logic          ev_chain_end,
  input  logic          ev_resp_stat,
  input  logic          ev_sdio,
  input  logic          core_busy,
  input  logic          desc_busy,
  input  logic [13:0]   bus_live,
  output logic          irq,
  output logic          secure_cfg,
  output logic          timeout_any,
  output logic          error_any,
  output logic          chain_done
);
  localparam int NPAD = 32 - NIEN;

  logic [NFLAG-1:0] sticky_q, ev_vec, clr_vec;
  logic [NIEN-1:0]  ien_q;
  logic             stat_hit, ien_hit;

  assign stat_hit = bus_addr == STAT_OFS;
  assign ien_hit  = bus_addr == IEN_OFS;

  assign ev_vec  = {ev_sdio, ev_resp_stat, ev_chain_end, ev_desc_to, ev_resp_to,
                    ev_resp_err, ev_desc_err, ev_tx_err, ev_rx_err};
  assign clr_vec = (bus_wr && stat_hit) ? bus_wdata[NFLAG-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sticky_q <= '0;
      ien_q    <= '0;
      irq      <= 1'b0;
    end else begin
      sticky_q <= (sticky_q & ~clr_vec) | ev_vec;
      if (bus_wr && ien_hit)
        ien_q <= bus_wdata[NIEN-1:0];
      irq <= |(sticky_q & ien_q[NFLAG-1:0]);
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (stat_hit)
      bus_rdata = {core_busy, desc_busy, bus_live, sticky_q};
    else if (ien_hit)
      bus_rdata = {{NPAD{1'b0}}, ien_q};
  end

  assign secure_cfg  = ien_q[16];
  assign timeout_any = sticky_q[11] | sticky_q[12];
  assign error_any   = |sticky_q[10:0];
  assign chain_done  = sticky_q[13];
endmodule

module sdhost_irq_status_chk #(
  parameter int AW    = 8,
  parameter int NFLAG = 16,
  parameter int NIEN  = 17,
  parameter logic [AW-1:0] STAT_OFS = 8'h48,
  parameter logic [AW-1:0] IEN_OFS  = 8'h4C
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_wr,
  input logic [AW-1:0]    bus_addr,
  input logic [31:0]      bus_wdata,
  input logic [31:0]      bus_rdata,
  input logic             core_busy,
  input logic             desc_busy,
  input logic [NFLAG-1:0] sticky_q,
  input logic [NFLAG-1:0] ev_vec,
  input logic [NIEN-1:0]  ien_q,
  input logic             irq
);
  // R2 R4
  ev_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((sticky_q & $past(ev_vec)) == $past(ev_vec)));

  // R3
  no_spurious_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == STAT_OFS) |=> ((sticky_q & $past(sticky_q)) == $past(sticky_q)));

  // R5
  ien_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == IEN_OFS) |=> $stable(ien_q));

  // R6
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ($past(sticky_q & ien_q[NFLAG-1:0]) != '0));

  // R8
  live_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == STAT_OFS) |-> (bus_rdata[31] == core_busy && bus_rdata[30] == desc_busy));
endmodule

bind sdhost_irq_status sdhost_irq_status_chk #(
  .AW(AW), .NFLAG(NFLAG), .NIEN(NIEN), .STAT_OFS(STAT_OFS), .IEN_OFS(IEN_OFS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .core_busy(core_busy),
  .desc_busy(desc_busy), .sticky_q(sticky_q), .ev_vec(ev_vec),
  .ien_q(ien_q), .irq(irq)
);

// File: tb/sim_sdhost_irq_status.sv
`timescale 1ns/1ps
module sim_sdhost_irq_status;
  logic clk = 0, rst_n = 0;
  logic bus_wr = 0;
  logic [7:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [15:0] evb = 0;
  logic core_busy = 0, desc_busy = 0;
  logic [13:0] bus_live = 0;
  logic irq, secure_cfg, timeout_any, error_any, chain_done;

  always #2.5 clk = ~clk;

  sdhost_irq_status u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ev_rx_err(evb[7:0]), .ev_tx_err(evb[8]), .ev_desc_err(evb[9]),
    .ev_resp_err(evb[10]), .ev_resp_to(evb[11]), .ev_desc_to(evb[12]),
    .ev_chain_end(evb[13]), .ev_resp_stat(evb[14]), .ev_sdio(evb[15]),
    .core_busy(core_busy), .desc_busy(desc_busy), .bus_live(bus_live),
    .irq(irq), .secure_cfg(secure_cfg), .timeout_any(timeout_any),
    .error_any(error_any), .chain_done(chain_done)
  );

  typedef struct { string tag; int kind; logic [31:0] exp; } item_t;
  item_t q[$];
  event samp;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  // kind: 0 rdata, 1 irq, 2 secure_cfg, 3 timeout_any, 4 error_any, 5 chain_done
  function automatic logic [31:0] observe(int kind);
    case (kind)
      0: return bus_rdata;
      1: return {31'b0, irq};
      2: return {31'b0, secure_cfg};
      3: return {31'b0, timeout_any};
      4: return {31'b0, error_any};
      default: return {31'b0, chain_done};
    endcase
  endfunction

  initial forever begin
    @(samp);
    while (q.size() > 0) begin
      item_t it;
      logic [31:0] got;
      it = q.pop_front();
      got = observe(it.kind);
      n_run++;
      if (got !== it.exp) begin
        n_fail++;
        $display("FAIL %s: got %h expected %h", it.tag, got, it.exp);
      end
    end
  end

  task automatic expect_val(string tag, int kind, logic [31:0] exp);
    item_t it;
    it.tag = tag; it.kind = kind; it.exp = exp;
    q.push_back(it);
    -> samp;
    #0.1;
  endtask

  task automatic expect_reg(string tag, logic [7:0] a, logic [31:0] exp);
    bus_addr = a;
    #0.5;
    expect_val(tag, 0, exp);
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d, logic [15:0] ev);
    bus_wr = 1; bus_addr = a; bus_wdata = d; evb = ev;
    @(negedge clk);
    bus_wr = 0; evb = 0;
  endtask

  task automatic pulse(logic [15:0] ev);
    evb = ev;
    @(negedge clk);
    evb = 0;
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    expect_reg("R1 status reset", 8'h48, 32'h0);
    expect_reg("R1 enable reset", 8'h4C, 32'h0);
    expect_val("R1 irq reset", 1, 0);

    pulse(16'h2000);
    expect_reg("R2 chain end flag", 8'h48, 32'h0000_2000);
    expect_val("R9 chain_done", 5, 1);
    @(negedge clk);
    expect_val("R7 masked no irq", 1, 0);

    wr(8'h4C, 32'h0001_FFFF, 0);
    expect_reg("R5 enable readback", 8'h4C, 32'h0001_FFFF);
    expect_val("R5 secure_cfg set", 2, 1);
    expect_val("R6 irq one cycle later still 0", 1, 0);
    @(negedge clk);
    expect_val("R6 irq asserted", 1, 1);

    pulse(16'h0808);
    expect_reg("R2 rx and resp timeout", 8'h48, 32'h0000_2808);
    expect_val("R9 timeout_any", 3, 1);
    expect_val("R9 error_any", 4, 1);

    wr(8'h48, 32'h0000_0008, 0);
    expect_reg("R3 w1c rx bit", 8'h48, 32'h0000_2800);
    expect_val("R9 error_any cleared", 4, 0);

    wr(8'h4C, 32'h1234_5678, 0);
    expect_reg("R5 upper bits zero", 8'h4C, 32'h0000_5678);
    expect_val("R5 secure_cfg clear", 2, 0);

    wr(8'h48, 32'h0000_0800, 16'h0800);
    expect_reg("R4 set wins over clear", 8'h48, 32'h0000_2800);

    wr(8'h4C, 32'h0000_FFFF, 0);
    wr(8'h48, 32'h0000_FFFF, 0);
    expect_reg("R3 clear all", 8'h48, 32'h0);
    @(negedge clk);
    expect_val("R6 irq deasserted", 1, 0);

    pulse(16'hA000);
    wr(8'h48, 32'h0000_8000, 0);
    expect_reg("R10 sdio ack only", 8'h48, 32'h0000_2000);

    core_busy = 1; desc_busy = 0; bus_live = 14'h2A5A;
    expect_reg("R8 live bits", 8'h48, 32'hAA5A_2000);
    wr(8'h48, 32'hFFFF_0000, 0);
    expect_reg("R8 live bits ignore write", 8'h48, 32'hAA5A_2000);
    core_busy = 0; bus_live = 0;

    wr(8'h40, 32'hFFFF_FFFF, 0);
    expect_reg("R11 unmapped reads zero", 8'h40, 32'h0);
    expect_reg("R11 status untouched", 8'h48, 32'h0000_2000);
    expect_reg("R11 enable untouched", 8'h4C, 32'h0000_FFFF);

    wr(8'h4C, 32'h0, 0);
    wr(8'h48, 32'h0000_FFFF, 0);
    pulse(16'h0100);
    expect_reg("R7 masked flag recorded", 8'h48, 32'h0000_0100);
    @(negedge clk);
    @(negedge clk);
    expect_val("R7 masked flag no irq", 1, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule